// File: doc/BRIEF.md
# UART Receive Line Status with Error-Tagged FIFO

This block is the status side of a classic UART. Each character that the receive shifter completes comes in with its data byte and three tags: parity error, framing error and break. The block stores the character in a receive buffer. In single-buffer mode the buffer holds one character. In FIFO mode it holds `RX_DEPTH` characters. The block also counts how many characters wait in the transmit holding stage and whether the transmit shifter is busy. Both views are combined into one read-only line status byte at offset 5 of a small read bus. Offset 0 of the same bus pops the oldest received byte.

Error tags are kept with each character. The parity, framing and break bits show only the tags of the character at the head of the buffer. A summary flag covers the whole FIFO. It rises as soon as a tagged character is held anywhere in the FIFO. Once raised, it stays up until a status read happens at a moment when no tagged characters remain. The break, framing, parity and overrun bits clear when the status byte is read. While any of them shows, the block raises a line status interrupt request.

Top module: `uart_lsr_core`

## Requirements
- R1: After reset the status byte reads 0x60. Its layout is: bit7 error-in-FIFO, bit6 transmitter empty, bit5 transmit holding empty, bit4 break, bit3 framing error, bit2 parity error, bit1 overrun, bit0 data ready.
- R2: Bit0 is 1 exactly while at least one received character is held.
- R3: A character that arrives while the buffer is full sets overrun. Full means one character in single-buffer mode and `RX_DEPTH` characters in FIFO mode. The arriving character is discarded and the held contents are unchanged.
- R4: Bits 4, 3 and 2 show the break, framing and parity tags of the character at the head of the buffer.
- R5: A status read clears overrun, unless a new overrun happens in the same cycle. It also hides the head's tags until the head changes (pop, or push into an empty buffer).
- R6: In FIFO mode bit7 is 1 while any tagged character is held. In single-buffer mode bit7 always reads 0.
- R7: Once set, bit7 stays 1 after its tagged characters are popped. It clears only on a status read that leaves no tagged character held.
- R8: Bit5 is 1 when the transmit holding stage is empty. That stage holds 1 character in single-buffer mode and `TX_DEPTH` in FIFO mode. A write when the stage is full is ignored. A load moves one character to the shifter only when the shifter is idle.
- R9: Bit6 is 1 only when the holding stage is empty and the shifter is idle. The shifter turns busy on a load and idle on `tx_sent`.
- R10: `line_irq` is 1 exactly while any of status bits 4 to 1 reads 1.
- R11: A read at offset 0 returns the head byte in arrival order and pops it. A read of an empty buffer returns 0.
- R12: `rd_data` answers in the same cycle as `rd_en`. The effects of the read (pop, clears) appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| rx_valid | input | 1 | Receive shifter completed a character (one-cycle pulse) |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity tag of the received byte |
| rx_frame_err | input | 1 | Framing tag of the received byte |
| rx_break | input | 1 | Break tag: line held low for a whole character time |
| tx_write | input | 1 | Character written into transmit holding stage |
| tx_load | input | 1 | Shifter requests the next character |
| tx_sent | input | 1 | Shifter finished its character |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register offset (0 = receive data, 5 = status) |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| line_irq | output | 1 | Receiver line status interrupt request |

## Verification
Every stimulus pulse (a received character, a transmit write, load or sent) is captured by one clock edge. Its effect is therefore visible in the status byte from the following cycle. A read returns data combinationally within its own strobe cycle. Any pop or clear it causes shows from the next cycle. The bench drives each input for exactly one cycle, starting on a falling edge. The scoreboard monitor samples `rd_data` and `line_irq` one nanosecond after that falling edge, while the strobe is still high and well before the capturing rising edge. Reads in a row are separated by an idle cycle, so each expected value reflects every earlier edge.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
    localparam int DATA_W = 8;
    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd5;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              pe;
        logic              fe;
        logic              bi;
    } rx_char_t;
endpackage

// File: rtl/uart_rx_tagfifo.sv
module uart_rx_tagfifo
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic             push_valid,
    input  rx_char_t         push_char,
    input  logic             pop,
    output rx_char_t         head,
    output logic [CNT_W-1:0] count,
    output logic             overrun,
    output logic             head_change,
    output logic             err_any_next
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] err_cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    rx_char_t    mem [DEPTH];
    logic        full, do_push, do_pop, push_err, head_err;

    always_comb begin
        st_d     = st_q;
        full     = fifo_mode ? (st_q.cnt == CNT_W'(DEPTH)) : (st_q.cnt != '0);
        do_push  = push_valid & ~full;
        do_pop   = pop & (st_q.cnt != '0);
        overrun  = push_valid & full;
        push_err = push_char.pe | push_char.fe | push_char.bi;
        head     = mem[st_q.rd_ptr];
        head_err = head.pe | head.fe | head.bi;
        head_change = do_pop | (do_push & (st_q.cnt == '0));

        if (do_push)
            st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        if (do_pop)
            st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        st_d.cnt     = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        st_d.err_cnt = st_q.err_cnt + CNT_W'(do_push & push_err)
                                    - CNT_W'(do_pop & head_err);
        err_any_next = (st_d.err_cnt != '0);
        count        = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr_ptr] <= push_char;
    end
endmodule

// File: rtl/uart_tx_occupancy.sv
module uart_tx_occupancy #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic wr,
    input  logic load,
    input  logic sent,
    output logic hold_empty,
    output logic tx_empty
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      full, do_wr, do_load;

    always_comb begin
        st_d    = st_q;
        full    = fifo_mode ? (st_q.cnt == CNT_W'(DEPTH)) : (st_q.cnt != '0);
        do_wr   = wr & ~full;
        do_load = load & (st_q.cnt != '0) & ~st_q.busy;
        st_d.cnt = st_q.cnt + CNT_W'(do_wr) - CNT_W'(do_load);
        if (do_load)   st_d.busy = 1'b1;
        else if (sent) st_d.busy = 1'b0;
        hold_empty = (st_q.cnt == '0);
        tx_empty   = hold_empty & ~st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
    import uart_lsr_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16,
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              tx_write,
    input  logic              tx_load,
    input  logic              tx_sent,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              line_irq
);
    typedef struct packed {
        logic oe;
        logic tag_hidden;
        logic eif;
    } lsr_state_t;

    lsr_state_t         st_d, st_q;
    rx_char_t           in_char, head;
    logic [RX_CNT_W-1:0] rx_count;
    logic               overrun, head_change, err_any_next;
    logic               hold_empty, tx_empty;
    logic               stat_rd, data_rd, dready;
    logic               show_bi, show_fe, show_pe;
    logic [7:0]         lsr;
    logic               oe_flag, eif_flag;

    assign in_char = '{data: rx_data, pe: rx_parity_err, fe: rx_frame_err, bi: rx_break};
    assign stat_rd = rd_en & (rd_addr == ADDR_STAT);
    assign data_rd = rd_en & (rd_addr == ADDR_DATA);

    uart_rx_tagfifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .push_valid(rx_valid), .push_char(in_char), .pop(data_rd),
        .head(head), .count(rx_count), .overrun(overrun),
        .head_change(head_change), .err_any_next(err_any_next)
    );

    uart_tx_occupancy #(.DEPTH(TX_DEPTH)) u_txo (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .wr(tx_write), .load(tx_load), .sent(tx_sent),
        .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always_comb begin
        st_d = st_q;
        st_d.oe  = overrun | (st_q.oe & ~stat_rd);
        st_d.eif = err_any_next | (st_q.eif & ~stat_rd);
        if (head_change)  st_d.tag_hidden = 1'b0;
        else if (stat_rd) st_d.tag_hidden = 1'b1;

        dready  = (rx_count != '0);
        show_bi = dready & ~st_q.tag_hidden & head.bi;
        show_fe = dready & ~st_q.tag_hidden & head.fe;
        show_pe = dready & ~st_q.tag_hidden & head.pe;
        lsr = {fifo_mode & st_q.eif, tx_empty, hold_empty,
               show_bi, show_fe, show_pe, st_q.oe, dready};

        if (stat_rd)      rd_data = lsr;
        else if (data_rd) rd_data = dready ? head.data : '0;
        else              rd_data = '0;
        line_irq = st_q.oe | show_pe | show_fe | show_bi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe_flag  = st_q.oe;
    assign eif_flag = st_q.eif;
endmodule

// File: rtl/uart_lsr_checker.sv
module uart_lsr_checker #(
    parameter int RX_DEPTH = 16,
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fifo_mode,
    input logic                rx_valid,
    input logic                rd_en,
    input logic [2:0]          rd_addr,
    input logic [7:0]          rd_data,
    input logic                line_irq,
    input logic [RX_CNT_W-1:0] rx_count,
    input logic                oe_flag,
    input logic                eif_flag,
    input logic                err_any_next
);
    logic stat_rd, pop_rd, full;
    assign stat_rd = rd_en && rd_addr == 3'd5;
    assign pop_rd  = rd_en && rd_addr == 3'd0;
    assign full    = fifo_mode ? (rx_count == RX_CNT_W'(RX_DEPTH)) : (rx_count != '0);

    a_r2_ready_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> rd_data[0] == (rx_count != '0));
    a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && full) |=> oe_flag);
    a_r3_overrun_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && full && !pop_rd) |=> $stable(rx_count));
    a_r5_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(rx_valid && full)) |=> !oe_flag);
    a_r6_summary_hidden_single: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fifo_mode) |-> !rd_data[7]);
    a_r7_summary_held: assert property (@(posedge clk) disable iff (!rst_n)
        err_any_next |=> eif_flag);
    a_r9_empty_implies_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> !(rd_data[6] && !rd_data[5]));
    a_r10_irq_tracks_bits: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> line_irq == (|rd_data[4:1]));
endmodule

bind uart_lsr_core uart_lsr_checker #(.RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_valid(rx_valid),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .line_irq(line_irq),
    .rx_count(rx_count), .oe_flag(oe_flag), .eif_flag(eif_flag),
    .err_any_next(err_any_next)
);

// File: tb/uart_lsr_core_tb.sv
module uart_lsr_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0;
    logic       tx_write = 1'b0, tx_load = 1'b0, tx_sent = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       line_irq;

    typedef struct {
        logic [7:0] exp;
        logic       is_stat;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    uart_lsr_core u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break),
        .tx_write(tx_write), .tx_load(tx_load), .tx_sent(tx_sent),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .line_irq(line_irq)
    );

    // monitor: samples 1 ns after the falling edge on which the driver raised rd_en
    always @(negedge clk) begin
        #1;
        if (rd_en && rst_n) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL %s: read with no expected item, actual %02h expected none", "R12", rd_data);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rd_data actual %02h expected %02h", it.tag, rd_data, it.exp);
                end
                if (it.is_stat) begin
                    n_checks++;
                    if (line_irq !== (|it.exp[4:1])) begin
                        n_fail++;
                        $display("FAIL R10 (%s): line_irq actual %0b expected %0b",
                                 it.tag, line_irq, |it.exp[4:1]);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.exp = exp; it.is_stat = (a == 3'd5); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = '0;
    endtask

    task automatic rx(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_parity_err = pe; rx_frame_err = fe; rx_break = bi;
        @(negedge clk);
        rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
    endtask

    task automatic tx(input logic w, input logic l, input logic s);
        @(negedge clk);
        tx_write = w; tx_load = l; tx_sent = s;
        @(negedge clk);
        tx_write = 1'b0; tx_load = 1'b0; tx_sent = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd5, 8'h60, "R1 reset value");

        // single-buffer mode: overrun and discard
        rx(8'hA5, 0, 0, 0);
        rd(3'd5, 8'h61, "R2 data ready");
        rx(8'h3C, 0, 0, 0);
        rd(3'd5, 8'h63, "R3 single overrun");
        rd(3'd5, 8'h61, "R5 overrun cleared");
        rd(3'd0, 8'hA5, "R3 first byte kept");
        rd(3'd5, 8'h60, "R2 empty after pop");

        // single-buffer mode: parity tag, summary hidden
        rx(8'h55, 1, 0, 0);
        rd(3'd5, 8'h65, "R6 parity shown, summary hidden");
        rd(3'd5, 8'h61, "R5 parity hidden after read");
        rd(3'd0, 8'h55, "R11 data pop");
        rd(3'd5, 8'h60, "R7 idle");

        // FIFO mode: head-only tags and sticky summary
        fifo_mode = 1'b1;
        rx(8'h11, 0, 0, 0);
        rx(8'h22, 0, 1, 0);
        rx(8'h33, 0, 0, 0);
        rd(3'd5, 8'hE1, "R6 summary with clean head");
        rd(3'd0, 8'h11, "R11 first in order");
        rd(3'd5, 8'hE9, "R4 framing at head");
        rd(3'd5, 8'hE1, "R5 framing hidden, R7 summary kept");
        rd(3'd0, 8'h22, "R11 second in order");
        rd(3'd5, 8'hE1, "R7 summary sticky after pop");
        rd(3'd5, 8'h61, "R7 summary cleared");
        rd(3'd0, 8'h33, "R11 third in order");
        rd(3'd5, 8'h60, "R2 FIFO empty");

        // break tag
        rx(8'h00, 0, 0, 1);
        rd(3'd5, 8'hF1, "R4 break at head");
        rd(3'd0, 8'h00, "R11 break byte");
        rd(3'd5, 8'hE0, "R7 summary sticky, empty");
        rd(3'd5, 8'h60, "R7 summary cleared on read");
        rd(3'd0, 8'h00, "R11 empty read returns 0");

        // FIFO overrun
        for (int i = 0; i < 16; i++) rx(8'(i * 7 + 1), 0, 0, 0);
        rx(8'hEE, 0, 0, 0);
        rd(3'd5, 8'h63, "R3 FIFO overrun");
        for (int i = 0; i < 16; i++) rd(3'd0, 8'(i * 7 + 1), "R3 FIFO contents kept");
        rd(3'd5, 8'h60, "R3 discarded byte absent");

        // transmit side, FIFO mode
        tx(1, 0, 0);
        rd(3'd5, 8'h00, "R8 holding occupied");
        tx(0, 1, 0);
        rd(3'd5, 8'h20, "R9 shifter busy");
        tx(0, 0, 1);
        rd(3'd5, 8'h60, "R9 all empty");
        tx(1, 0, 0);
        tx(1, 0, 0);
        tx(0, 1, 0);
        rd(3'd5, 8'h00, "R8 one left in FIFO");
        tx(0, 1, 0);
        rd(3'd5, 8'h00, "R8 load blocked while busy");
        tx(0, 0, 1);
        tx(0, 1, 0);
        rd(3'd5, 8'h20, "R8 FIFO drained");
        tx(0, 0, 1);
        rd(3'd5, 8'h60, "R9 idle again");

        // transmit side, single-buffer: second write ignored
        fifo_mode = 1'b0;
        tx(1, 0, 0);
        tx(1, 0, 0);
        tx(0, 1, 0);
        rd(3'd5, 8'h20, "R8 extra write ignored");
        tx(0, 0, 1);
        rd(3'd5, 8'h60, "R9 idle single");

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R12: pending items actual %0d expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule